// File: doc/BRIEF.md
# Program Counter Sequencer with Branch and Jump Selection

This block is the fetch front end of a single-cycle processor core. It holds the program counter as a 30-bit word address. It presents that address to a word-addressed instruction memory and hands the returned word on as the current instruction. The byte address is formed by appending two zero bits to the word address.

On every clock edge the block loads one of three candidates into the counter. The first is the sequential successor. The second is a relative branch target, taken when the branch strobe is set and the ALU reports a zero result. The third is an absolute jump target, built from the upper bits of the current counter and the 26-bit target field of the instruction. The jump strobe wins over the branch strobe.

The fetched word does not depend on the instruction type. Only the choice of the next counter value changes from one instruction to the next.

Top module: `fetch_unit`

## Requirements
- R1: A synchronous active-high reset loads the word counter with 0. After the reset edge, `imemAddr` reads 0 and `pcByte` reads 0.
- R2: `imemAddr` equals the word counter and `pcByte` equals the word counter followed by two zero bits. `instr` equals the memory word `imemRdata` returned for the current address, whatever the control inputs are.
- R3: With `jumpEn`=0 and `branchEn`=0, the next counter is the current counter plus 1, wrapping modulo 2^30. This step equals +4 on the byte address.
- R4: With `jumpEn`=0, `branchEn`=1 and `aluZero`=1, the next counter is the current counter + 1 + the sign extension of `instr[15:0]`, modulo 2^30. Bit 15 is the sign bit.
- R5: With `jumpEn`=0, `branchEn`=1 and `aluZero`=0, the next counter is the current counter plus 1.
- R6: With `jumpEn`=1, the next counter is bits [29:26] of the current counter, not of the incremented counter, concatenated above `instr[25:0]`. On the byte address this is pcByte[31:28], then target, then 00.
- R7: When `jumpEn` and `branchEn` are both 1, the jump of R6 is taken, whatever `aluZero` is.
- R8: With `branchEn`=0 and `jumpEn`=0, `aluZero` has no effect, and the next counter is the current counter plus 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| branchEn | input | 1 | Current instruction is a conditional branch |
| jumpEn | input | 1 | Current instruction is an absolute jump |
| aluZero | input | 1 | ALU result-is-zero flag for the current instruction |
| imemRdata | input | 32 | Word read from instruction memory at `imemAddr` |
| imemAddr | output | 30 | Word address sent to instruction memory |
| instr | output | 32 | Current instruction |
| pcByte | output | 32 | Byte program counter (word counter with two zero bits appended) |

## Verification
The following checks run on every cycle. The select strobes stay one-hot, and a jump request always wins over a branch request. An untaken branch or a plain step advances the counter by exactly one, and a jump keeps the counter's top four bits. Reset always clears the counter.

Only the bench scenarios can show that the branch offset is added with the correct sign and that the sequential step wraps at the top of the address space. They also show that the jump's upper bits come from the current counter when incrementing would carry into them, and that the fetched word follows the address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int PC_W_DEF    = 30;
  localparam int INSTR_W_DEF = 32;
  localparam int IMM_W_DEF   = 16;
  localparam int TGT_W_DEF   = 26;

  // One-hot next-counter strobes from control to datapath
  typedef struct packed {
    logic selSeq;
    logic selBranch;
    logic selJump;
  } pcSel_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   branchEn,
  input  logic   jumpEn,
  input  logic   aluZero,
  output pcSel_t sel
);
  logic brTaken;

  always_comb begin
    brTaken       = branchEn & aluZero;
    sel.selJump   = jumpEn;
    sel.selBranch = ~jumpEn & brTaken;
    sel.selSeq    = ~jumpEn & ~brTaken;
  end

  // R7: exactly one candidate chosen per cycle
  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({sel.selSeq, sel.selBranch, sel.selJump}) == 1);

  // R7: jump request overrides any branch request
  p_jump_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (jumpEn && branchEn) |-> (sel.selJump && !sel.selBranch));

  // R5: branch with nonzero flag falls through to the sequential path
  p_branch_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (branchEn && !aluZero && !jumpEn) |-> sel.selSeq);

  // R8: flag is irrelevant without a branch or jump request
  p_zero_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (!branchEn && !jumpEn) |-> sel.selSeq);
endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int PC_W  = PC_W_DEF,
  parameter int IMM_W = IMM_W_DEF,
  parameter int TGT_W = TGT_W_DEF
)(
  input  logic             clk,
  input  logic             rst,
  input  pcSel_t           sel,
  input  logic [TGT_W-1:0] tgtField,
  output logic [PC_W-1:0]  pcWord
);
  localparam int UP_W  = PC_W - TGT_W;
  localparam int EXT_W = PC_W - IMM_W;

  logic [PC_W-1:0] pcSeq;
  logic [PC_W-1:0] brOff;
  logic [PC_W-1:0] pcBr;
  logic [PC_W-1:0] pcJmp;
  logic [PC_W-1:0] pcNext;

  always_comb begin
    pcSeq = pcWord + {{(PC_W-1){1'b0}}, 1'b1};
    brOff = {{EXT_W{tgtField[IMM_W-1]}}, tgtField[IMM_W-1:0]};
    pcBr  = pcSeq + brOff;
    pcJmp = {pcWord[PC_W-1 -: UP_W], tgtField};
    if (sel.selJump)        pcNext = pcJmp;
    else if (sel.selBranch) pcNext = pcBr;
    else                    pcNext = pcSeq;
  end

  always_ff @(posedge clk) begin
    if (rst) pcWord <= '0;
    else     pcWord <= pcNext;
  end

  // R1: reset clears the counter on the next edge
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (pcWord == '0));

  // R3: sequential choice advances by one word
  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    sel.selSeq |=> (pcWord == $past(pcWord) + {{(PC_W-1){1'b0}}, 1'b1}));

  // R6: jump keeps the upper bits of the counter it left
  p_jump_upper_r6: assert property (@(posedge clk) disable iff (rst)
    sel.selJump |=> (pcWord[PC_W-1 -: UP_W] == $past(pcWord[PC_W-1 -: UP_W])));
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int PC_W    = PC_W_DEF,
  parameter int INSTR_W = INSTR_W_DEF,
  parameter int IMM_W   = IMM_W_DEF,
  parameter int TGT_W   = TGT_W_DEF
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               branchEn,
  input  logic               jumpEn,
  input  logic               aluZero,
  input  logic [INSTR_W-1:0] imemRdata,
  output logic [PC_W-1:0]    imemAddr,
  output logic [INSTR_W-1:0] instr,
  output logic [PC_W+1:0]    pcByte
);
  pcSel_t          sel;
  logic [PC_W-1:0] pcWord;

  fetch_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .branchEn (branchEn),
    .jumpEn   (jumpEn),
    .aluZero  (aluZero),
    .sel      (sel)
  );

  fetch_dp #(.PC_W(PC_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .tgtField (imemRdata[TGT_W-1:0]),
    .pcWord   (pcWord)
  );

  assign imemAddr = pcWord;
  assign instr    = imemRdata;
  assign pcByte   = {pcWord, 2'b00};
endmodule

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branchEn = 1'b0;
  logic        jumpEn = 1'b0;
  logic        aluZero = 1'b0;
  logic [31:0] salt = '0;
  logic [31:0] imemRdata;
  logic [29:0] imemAddr;
  logic [31:0] instr;
  logic [31:0] pcByte;

  int nChecks = 0;
  int nFails  = 0;
  logic [29:0] expPc = '0;

  always #4 clk = ~clk;

  function automatic logic [31:0] hashWord(input logic [29:0] a);
    return ({a, 2'b01} * 32'h9E3779B1) ^ {a[15:0], a[29:14]};
  endfunction

  function automatic logic [29:0] refNext(input logic [29:0] pc, input logic [31:0] ins,
                                          input logic br, input logic jp, input logic z);
    if (jp)           return {pc[29:26], ins[25:0]};
    else if (br && z) return pc + 30'd1 + {{14{ins[15]}}, ins[15:0]};
    else              return pc + 30'd1;
  endfunction

  assign imemRdata = hashWord(imemAddr) ^ salt;

  fetch_unit dut_i (
    .clk(clk), .rst(rst), .branchEn(branchEn), .jumpEn(jumpEn), .aluZero(aluZero),
    .imemRdata(imemRdata), .imemAddr(imemAddr), .instr(instr), .pcByte(pcByte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic br, input logic jp, input logic z, input logic [31:0] want);
    string tag;
    logic [29:0] nxt;
    branchEn = br; jumpEn = jp; aluZero = z;
    salt = want ^ hashWord(expPc);
    #1;
    check("R2 instr", instr, want);
    check("R2 pcByte", pcByte, {expPc, 2'b00});
    nxt = refNext(expPc, want, br, jp, z);
    if (jp && br)     tag = "R7";
    else if (jp)      tag = "R6";
    else if (br && z) tag = "R4";
    else if (br)      tag = "R5";
    else if (z)       tag = "R8";
    else              tag = "R3";
    @(posedge clk); @(negedge clk);
    expPc = nxt;
    check(tag, {2'b00, imemAddr}, {2'b00, expPc});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 addr", {2'b00, imemAddr}, 32'h0);
    check("R1 pcByte", pcByte, 32'h0);
    rst = 1'b0;
    expPc = '0;
    // R4: negative offset from 0 lands at top of space
    step(1'b1, 1'b0, 1'b1, 32'h1234_FFFE);
    // R3: wrap from all ones back to 0
    step(1'b0, 1'b0, 1'b0, 32'hDEAD_0000);
    step(1'b1, 1'b0, 1'b1, 32'h0000_FFFE);
    // R6: jump from top region keeps upper ones
    step(1'b0, 1'b1, 1'b0, 32'h0800_0005);
    // R7: both strobes set, jump wins
    step(1'b1, 1'b1, 1'b1, 32'h0BFF_FFFF);
    step(1'b0, 1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b1, 1'b0, 32'h03FF_FFFF);
    // R6: incrementing would carry into upper bits; current bits must be used
    step(1'b0, 1'b1, 1'b1, 32'h0000_0010);
    // R5: untaken branch with large offset
    step(1'b1, 1'b0, 1'b0, 32'h0000_8000);
    // R4: largest positive offset
    step(1'b1, 1'b0, 1'b1, 32'h0000_7FFF);
    // R8: flag alone changes nothing
    step(1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    // R7: jump wins even when the flag is clear
    step(1'b1, 1'b1, 1'b0, 32'h0123_4567);
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom % 2), 1'(($urandom % 4) == 0), 1'($urandom % 2), $urandom);
    end
    // R1: reset mid-run clears counter
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 midrun", {2'b00, imemAddr}, 32'h0);
    summary();
  end
endmodule